// File: doc/BRIEF.md
# Receiver-to-Transmitter Sample Stream Bridge

This block sits between the four sample output ports of a digital down-converter and the four sample input ports of a digital up-converter. It carries baseband words across in a fixed two-clock pipeline. The receive words are captured in a first register bank. They are then moved into a second, output register bank that drives the transmitter.

During that move the port pairs are crossed. Receive ports C and D feed transmit ports A and B, and receive ports A and B feed transmit ports C and D. When time-division-multiplexed (TDM) operation is selected, the single serial stream arriving on receive port D is placed on transmit port A, and the other transmit ports are held at zero. The frame sync travels through the same two stages, so it stays aligned with the data.

A small tracking state machine follows the frame so the transmitter knows which word is on the active lane. It has two states. ST_HUNT means no frame is known. ST_TRACK means the slot counter is advancing. Its transitions are:
- **hunt-to-track**: a sync arrives.
- **track-to-track**: the slot count advances or wraps, or a sync realigns it.
- **track-to-hunt or hunt-to-hunt**: the mode or format select changes.

The frame length depends on the selection:

| Mode | Format | Words per frame |
|------|--------|-----------------|
| Two-channel split-IQ | parallel | 1 |
| Two-channel split-IQ | TDM | 4 |
| Four-channel | interleaved | 2 |
| Four-channel | TDM | 8 |

Top module: `rx_tx_stream_bridge`

## Requirements
- R1: While `rst_n` is low, every transmit port, `tx_sync`, `tx_slot` and `tx_lock` read zero.
- R2: A word and a sync value presented at the receive side before a rising edge appear at the transmit side exactly two rising edges later: `tx_sync` equals `rx_sync` delayed two clocks.
- R3: With `fmt_tdm`=0, the routing is `tx_a`=`rx_c`, `tx_b`=`rx_d`, `tx_c`=`rx_a` and `tx_d`=`rx_b`, each delayed two clocks, in both modes.
- R4: With `fmt_tdm`=1, `tx_a` carries `rx_d` delayed two clocks, and `tx_b`, `tx_c` and `tx_d` are zero.
- R5: Split-IQ parallel (`mode_quad`=0, `fmt_tdm`=0) has a one-word frame. While locked, `tx_slot` is always 0, with I and Q on paired ports in the same cycle.
- R6: Split-IQ TDM (`mode_quad`=0, `fmt_tdm`=1) has a four-word frame. Slots 0 to 3 carry QB, IB, QA and IA in that order.
- R7: Four-channel interleaved (`mode_quad`=1, `fmt_tdm`=0) has a two-word frame. Slot 0 is I and slot 1 is Q.
- R8: Four-channel TDM (`mode_quad`=1, `fmt_tdm`=1) has an eight-word frame. Slots 0 to 7 carry QD, ID, QC, IC, QB, IB, QA and IA.
- R9: After reset, `tx_lock` is 0 and `tx_slot` is 0 until the first sync. The word carried with a sync has slot 0 and lock 1. Without a sync, the slot then advances by one per clock and wraps at the frame length.
- R10: In any cycle after the first post-reset cycle where {`mode_quad`,`fmt_tdm`} differs from the previous cycle, the tracker returns to hunting. That word carries lock 0 and slot 0, and a sync in that same cycle is ignored for tracking.
- R11: A sync that arrives at a slot other than the expected wrap forces that word to slot 0, and counting restarts from it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_quad | input | 1 | 0 = two-channel split-IQ, 1 = four-channel |
| fmt_tdm | input | 1 | 0 = parallel/interleaved, 1 = TDM |
| rx_sync | input | 1 | Frame sync from the down-converter |
| rx_a | input | SW | Down-converter port A word |
| rx_b | input | SW | Down-converter port B word |
| rx_c | input | SW | Down-converter port C word |
| rx_d | input | SW | Down-converter port D word (TDM source) |
| tx_a | output | SW | Up-converter port A word (TDM destination) |
| tx_b | output | SW | Up-converter port B word |
| tx_c | output | SW | Up-converter port C word |
| tx_d | output | SW | Up-converter port D word |
| tx_sync | output | 1 | Sync aligned with the transmit words |
| tx_slot | output | 3 | Slot index of the word on the active lane |
| tx_lock | output | 1 | Frame position known for this word |

## Verification
Two events can fall in the same clock. The first pair is a change of the mode or format select together with a sync pulse. The bench drives them together and expects hunting with lock 0, as R10 requires, rather than a fresh lock. The second pair is a sync that arrives while the counter sits mid-frame, so that realignment and the advance compete. The bench expects slot 0 from that word on.

// File: rtl/bridge_pkg.sv
package bridge_pkg;

    localparam int PORTS  = 4;
    localparam int SLOT_W = 3;

    typedef enum logic {
        ST_HUNT  = 1'b0,
        ST_TRACK = 1'b1
    } trk_state_e;

    // words per frame for each mode/format pair
    function automatic logic [SLOT_W:0] frame_len(input logic quad, input logic tdm);
        logic [SLOT_W:0] len;
        unique case ({quad, tdm})
            2'b00:   len = (SLOT_W+1)'(1);
            2'b01:   len = (SLOT_W+1)'(4);
            2'b10:   len = (SLOT_W+1)'(2);
            default: len = (SLOT_W+1)'(8);
        endcase
        return len;
    endfunction

endpackage

// File: rtl/bridge_slot_fsm.sv
module bridge_slot_fsm
    import bridge_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_quad,
    input  logic              fmt_tdm,
    input  logic              sync_in,
    output logic [SLOT_W-1:0] slot,
    output logic              lock
);

    trk_state_e        state_q, state_d;
    logic [SLOT_W-1:0] cnt_q, cnt_d;
    logic [1:0]        cfg_q;
    logic              prim_q;
    logic              chg;
    logic [SLOT_W:0]   len;
    logic [SLOT_W:0]   inc;
    logic [SLOT_W-1:0] after_sync;

    assign chg        = prim_q && (cfg_q != {mode_quad, fmt_tdm});
    assign len        = frame_len(mode_quad, fmt_tdm);
    assign inc        = {1'b0, cnt_q} + (SLOT_W+1)'(1);
    assign after_sync = (len > (SLOT_W+1)'(1)) ? SLOT_W'(1) : '0;

    // next-state and next-count
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_HUNT: begin
                if (!chg && sync_in) begin
                    state_d = ST_TRACK;
                    cnt_d   = after_sync;
                end else begin
                    cnt_d = '0;
                end
            end
            ST_TRACK: begin
                if (chg) begin
                    state_d = ST_HUNT;
                    cnt_d   = '0;
                end else if (sync_in) begin
                    cnt_d = after_sync;
                end else if (inc >= len) begin
                    cnt_d = '0;
                end else begin
                    cnt_d = inc[SLOT_W-1:0];
                end
            end
            default: begin
                state_d = ST_HUNT;
                cnt_d   = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_HUNT;
            cnt_q   <= '0;
            cfg_q   <= '0;
            prim_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            cfg_q   <= {mode_quad, fmt_tdm};
            prim_q  <= 1'b1;
        end
    end

    // outputs for the word present this cycle
    always_comb begin
        slot = '0;
        lock = 1'b0;
        unique case (state_q)
            ST_HUNT: begin
                lock = !chg && sync_in;
            end
            ST_TRACK: begin
                lock = !chg;
                slot = (!chg && !sync_in) ? cnt_q : '0;
            end
            default: begin
                lock = 1'b0;
            end
        endcase
    end

    AST_CHG_TO_HUNT:   assert property (@(posedge clk) disable iff (!rst_n)
        chg |=> (state_q == ST_HUNT)); // R10
    AST_SYNC_LOCKS:    assert property (@(posedge clk) disable iff (!rst_n)
        (sync_in && !chg) |=> (state_q == ST_TRACK)); // R9
    AST_SLOT_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        lock |-> ({1'b0, slot} < len)); // R6
    AST_HUNT_NO_SLOT:  assert property (@(posedge clk) disable iff (!rst_n)
        !lock |-> (slot == '0)); // R9

endmodule

// File: rtl/bridge_capture.sv
module bridge_capture
    import bridge_pkg::*;
#(
    parameter int SW = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [PORTS-1:0][SW-1:0]  din,
    input  logic                      sync_in,
    input  logic                      tdm_in,
    input  logic [SLOT_W-1:0]         slot_in,
    input  logic                      lock_in,
    output logic [PORTS-1:0][SW-1:0]  dq,
    output logic                      sync_q,
    output logic                      tdm_q,
    output logic [SLOT_W-1:0]         slot_q,
    output logic                      lock_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dq     <= '0;
            sync_q <= 1'b0;
            tdm_q  <= 1'b0;
            slot_q <= '0;
            lock_q <= 1'b0;
        end else begin
            dq     <= din;
            sync_q <= sync_in;
            tdm_q  <= tdm_in;
            slot_q <= slot_in;
            lock_q <= lock_in;
        end
    end

endmodule

// File: rtl/bridge_route.sv
module bridge_route
    import bridge_pkg::*;
#(
    parameter int SW = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [PORTS-1:0][SW-1:0]  din,
    input  logic                      sync_in,
    input  logic                      tdm_in,
    input  logic [SLOT_W-1:0]         slot_in,
    input  logic                      lock_in,
    output logic [PORTS-1:0][SW-1:0]  dout,
    output logic                      sync_out,
    output logic [SLOT_W-1:0]         slot_out,
    output logic                      lock_out
);

    localparam int HALF     = PORTS / 2;
    localparam int TDM_SRC  = PORTS - 1;

    for (genvar g = 0; g < PORTS; g++) begin : g_lane
        localparam int PAR_SRC = (g + HALF) % PORTS;
        logic [SW-1:0] pick;
        if (g == 0) begin : g_tdm_dst
            assign pick = tdm_in ? din[TDM_SRC] : din[PAR_SRC];
        end else begin : g_par_only
            assign pick = tdm_in ? '0 : din[PAR_SRC];
        end
        always_ff @(posedge clk) begin
            if (!rst_n) dout[g] <= '0;
            else        dout[g] <= pick;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_out <= 1'b0;
            slot_out <= '0;
            lock_out <= 1'b0;
        end else begin
            sync_out <= sync_in;
            slot_out <= slot_in;
            lock_out <= lock_in;
        end
    end

endmodule

// File: rtl/rx_tx_stream_bridge.sv
module rx_tx_stream_bridge
    import bridge_pkg::*;
#(
    parameter int SW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_quad,
    input  logic              fmt_tdm,
    input  logic              rx_sync,
    input  logic [SW-1:0]     rx_a,
    input  logic [SW-1:0]     rx_b,
    input  logic [SW-1:0]     rx_c,
    input  logic [SW-1:0]     rx_d,
    output logic [SW-1:0]     tx_a,
    output logic [SW-1:0]     tx_b,
    output logic [SW-1:0]     tx_c,
    output logic [SW-1:0]     tx_d,
    output logic              tx_sync,
    output logic [SLOT_W-1:0] tx_slot,
    output logic              tx_lock
);

    logic [PORTS-1:0][SW-1:0] rx_bus, s1_bus, tx_bus;
    logic [SLOT_W-1:0]        cur_slot, s1_slot;
    logic                     cur_lock, s1_lock, s1_sync, s1_tdm;

    assign rx_bus = {rx_d, rx_c, rx_b, rx_a};
    assign tx_a   = tx_bus[0];
    assign tx_b   = tx_bus[1];
    assign tx_c   = tx_bus[2];
    assign tx_d   = tx_bus[3];

    bridge_slot_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_quad (mode_quad),
        .fmt_tdm   (fmt_tdm),
        .sync_in   (rx_sync),
        .slot      (cur_slot),
        .lock      (cur_lock)
    );

    bridge_capture #(.SW(SW)) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .din     (rx_bus),
        .sync_in (rx_sync),
        .tdm_in  (fmt_tdm),
        .slot_in (cur_slot),
        .lock_in (cur_lock),
        .dq      (s1_bus),
        .sync_q  (s1_sync),
        .tdm_q   (s1_tdm),
        .slot_q  (s1_slot),
        .lock_q  (s1_lock)
    );

    bridge_route #(.SW(SW)) u_route (
        .clk      (clk),
        .rst_n    (rst_n),
        .din      (s1_bus),
        .sync_in  (s1_sync),
        .tdm_in   (s1_tdm),
        .slot_in  (s1_slot),
        .lock_in  (s1_lock),
        .dout     (tx_bus),
        .sync_out (tx_sync),
        .slot_out (tx_slot),
        .lock_out (tx_lock)
    );

    // cycles since reset release, saturating at the pipeline depth
    logic [1:0] warm_q;
    always_ff @(posedge clk) begin
        if (!rst_n)              warm_q <= '0;
        else if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
    end

    AST_SYNC_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'd2) |-> (tx_sync == $past(rx_sync, 2))); // R2
    AST_PAR_SWAP:     assert property (@(posedge clk) disable iff (!rst_n)
        ((warm_q == 2'd2) && !$past(fmt_tdm, 2)) |-> (tx_a == $past(rx_c, 2) && tx_c == $past(rx_a, 2))); // R3
    AST_TDM_QUIET:    assert property (@(posedge clk) disable iff (!rst_n)
        ((warm_q == 2'd2) && $past(fmt_tdm, 2)) |-> (tx_b == '0 && tx_c == '0 && tx_d == '0)); // R4
    AST_RESET_QUIET:  assert property (@(posedge clk)
        !rst_n |=> (!tx_sync && !tx_lock)); // R1

endmodule

// File: tb/rx_tx_stream_bridge_tb.sv
module rx_tx_stream_bridge_tb;

    localparam int CLK_PERIOD = 10;
    localparam int SW = 16;

    typedef struct {
        logic [SW-1:0] a, b, c, d;
        logic          sy, lk;
        logic [2:0]    sl;
        int            rq_data, rq_slot;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_quad = 1'b0, fmt_tdm = 1'b0, rx_sync = 1'b0;
    logic [SW-1:0] rx_a = '0, rx_b = '0, rx_c = '0, rx_d = '0;
    logic [SW-1:0] tx_a, tx_b, tx_c, tx_d;
    logic tx_sync, tx_lock;
    logic [2:0] tx_slot;

    int checks = 0, errors = 0;
    bit finished = 0;
    exp_t q[$];

    // model state
    bit m_prim = 0, m_track = 0;
    int m_cnt = 0;
    logic [1:0] m_cfg = '0;
    logic cur_mode = 0, cur_fmt = 0;
    int seq = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_tx_stream_bridge #(.SW(SW)) u_dut (
        .clk(clk), .rst_n(rst_n), .mode_quad(mode_quad), .fmt_tdm(fmt_tdm),
        .rx_sync(rx_sync), .rx_a(rx_a), .rx_b(rx_b), .rx_c(rx_c), .rx_d(rx_d),
        .tx_a(tx_a), .tx_b(tx_b), .tx_c(tx_c), .tx_d(tx_d),
        .tx_sync(tx_sync), .tx_slot(tx_slot), .tx_lock(tx_lock)
    );

    function automatic int flen(logic qd, logic td);
        if (!qd) return td ? 4 : 1;
        return td ? 8 : 2;
    endfunction

    task automatic chk(bit ok, int rq, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL R%0d %s: actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    // monitor side: compare the oldest expectation with the ports
    task automatic monitor_pop();
        exp_t e;
        e = q.pop_front();
        chk({tx_a, tx_b, tx_c, tx_d} == {e.a, e.b, e.c, e.d}, e.rq_data, "lanes",
            {tx_a, tx_b, tx_c, tx_d}, {e.a, e.b, e.c, e.d});
        chk(tx_sync == e.sy, 2, "sync", tx_sync, e.sy);                 // R2
        chk({tx_lock, tx_slot} == {e.lk, e.sl}, e.rq_slot, "lock/slot",
            {tx_lock, tx_slot}, {e.lk, e.sl});
    endtask

    // driver side: one sample cycle
    task automatic step(logic sy);
        exp_t e;
        bit chg, misplaced;
        int len;
        logic [SW-1:0] va, vb, vc, vd;
        @(negedge clk);
        if (q.size() == 2) monitor_pop();
        seq++;
        va = SW'(16'h1000 + seq); vb = SW'(16'h2000 + seq);
        vc = SW'(16'h3000 + seq); vd = SW'(16'h4000 + seq);
        len = flen(cur_mode, cur_fmt);
        chg = m_prim && ({cur_mode, cur_fmt} != m_cfg);
        misplaced = sy && m_track && (m_cnt != 0);
        if (cur_fmt) begin
            e.a = vd; e.b = '0; e.c = '0; e.d = '0; e.rq_data = 4;        // R4
        end else begin
            e.a = vc; e.b = vd; e.c = va; e.d = vb; e.rq_data = 3;        // R3
        end
        e.sy = sy;
        if (chg) begin
            e.lk = 0; e.sl = 0; m_track = 0; m_cnt = 0; e.rq_slot = 10;   // R10
        end else if (sy) begin
            e.lk = 1; e.sl = 0; m_track = 1; m_cnt = (len > 1) ? 1 : 0;
            e.rq_slot = misplaced ? 11 : 9;                               // R11, R9
        end else if (m_track) begin
            e.lk = 1; e.sl = 3'(m_cnt);
            m_cnt = (m_cnt + 1 >= len) ? 0 : m_cnt + 1;
            e.rq_slot = !cur_mode ? (cur_fmt ? 6 : 5) : (cur_fmt ? 8 : 7); // R5..R8 per mode
        end else begin
            e.lk = 0; e.sl = 0; e.rq_slot = 9;                            // R9
        end
        m_cfg = {cur_mode, cur_fmt};
        m_prim = 1;
        q.push_back(e);
        mode_quad = cur_mode; fmt_tdm = cur_fmt; rx_sync = sy;
        rx_a = va; rx_b = vb; rx_c = vc; rx_d = vd;
    endtask

    task automatic run(logic md, logic fm, int n, int period, int offset);
        cur_mode = md; cur_fmt = fm;
        for (int k = 0; k < n; k++) step((period > 0) && (k % period == offset));
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rx_a = 16'hAAAA; rx_b = 16'hBBBB; rx_c = 16'hCCCC; rx_d = 16'hDDDD; rx_sync = 1;
        repeat (3) @(negedge clk);
        // R1: reset holds outputs at zero despite active inputs
        chk({tx_a, tx_b, tx_c, tx_d} == '0, 1, "reset lanes", {tx_a, tx_b, tx_c, tx_d}, 0);
        chk({tx_sync, tx_lock, tx_slot} == '0, 1, "reset ctl", {tx_sync, tx_lock, tx_slot}, 0);
        rx_sync = 0;
        rst_n = 1;
        // R9: hunting before the first sync, then R5 split parallel
        run(1'b0, 1'b0, 3, 0, 0);
        run(1'b0, 1'b0, 6, 3, 0);
        // R6: split TDM, sync every 4, then free running
        run(1'b0, 1'b1, 12, 4, 1);
        run(1'b0, 1'b1, 6, 0, 0);
        // R11: misplaced sync mid-frame
        step(1'b1); step(1'b0); step(1'b1); step(1'b0); step(1'b0);
        // R7: four-channel interleaved
        run(1'b1, 1'b0, 10, 2, 0);
        // R10: config change in the same cycle as a sync
        cur_fmt = 1'b1; step(1'b1);
        step(1'b0);
        // R8: four-channel TDM, sync once then wrap twice
        run(1'b1, 1'b1, 20, 20, 0);
        run(1'b1, 1'b1, 5, 8, 3);
        // R10: change back without sync
        run(1'b0, 1'b0, 4, 0, 0);
        // drain
        step(1'b0); step(1'b0);
        @(negedge clk);
        while (q.size() > 0) begin monitor_pop(); @(negedge clk); end
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule